// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block turns one active-low external interrupt pin into an interrupt request for a CPU. The pin goes through a clock-domain synchronizer. A falling edge on the synchronized level sets a request latch. A control bit picks between two sensing styles:

- **Edge style:** an acknowledge clears the request on the next clock.
- **Level style:** the request stays up for as long as the pin is low. It drops only after an acknowledge has been seen and the pin has also returned high. The two events may come in either order.

An acknowledge comes from one of two places: a one-cycle pulse from the CPU's vector fetch, or a software write of 1 to the acknowledge bit of the status/control register. Software can read three things at any time: the pending flag, whatever the mask setting; the mask bit, which only gates the request line to the CPU; and the synchronized pin level, for branch-on-pin tests. The register is written over a single-cycle write strobe and is always readable on a combinational read port.

Top module: `ext_irq_ctrl`

## Requirements
- R1: A falling edge on `irq_pin_n` is defined as synchronized level 1 followed by synchronized level 0. If the pin is driven low before clock edge k, the pending flag (read bit 3) is 1 after edge k+2 and still 0 after edge k+1.
- R2: In edge style (control bit 0 = 0), a one-cycle `vec_ack` pulse while a request is pending clears the pending flag at the next clock edge, even if the pin is still low.
- R3: A write with data bit 2 = 1 acts exactly like `vec_ack` and clears the pending flag at the next clock edge.
- R4: In level style (control bit 0 = 1), an acknowledge given while the pin is low leaves the flag set. The flag clears 3 clock edges after the pin returns high, with no further acknowledge needed.
- R5: In level style, if the pin has already returned high, an acknowledge clears the flag at the next clock edge. Without an acknowledge the flag stays set.
- R6: A falling edge that occurs after an acknowledge sets a new request.
- R7: If an acknowledge and a detected falling edge fall on the same clock edge, the edge wins and the flag stays 1.
- R8: The pending flag ignores the mask bit (bit 1). `cpu_irq` equals pending AND NOT mask, registered, so it changes one clock after either input changes.
- R9: Reset (`rst_n` low at a clock edge) clears the request, the mode bit, the mask bit and `cpu_irq`. A pin held low through reset raises no request afterwards.
- R10: Read bit 4 shows the synchronized pin level. It follows the pin two clock edges later.
- R11: Read bit 2 is always 0, and writes to bit 3 have no effect on the pending flag.
- R12: A pin that stays high or rises produces no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset, held at least 3 cycles |
| irq_pin_n | input | 1 | Asynchronous active-low interrupt pin |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data: bit0 mode, bit1 mask, bit2 acknowledge |
| reg_rdata | output | 8 | Read data: bit0 mode, bit1 mask, bit2 zero, bit3 pending, bit4 pin level |
| vec_ack | input | 1 | Vector-fetch acknowledge pulse |
| cpu_irq | output | 1 | Registered interrupt request to the CPU |

## Verification
Results fall due at fixed delays after each stimulus:

| Stimulus | Result | Due after edge |
|---|---|---|
| Pin change | Pin level read-back | 2nd |
| Pin drop | Pending flag | 3rd |
| Acknowledge | Flag clears (edge style, or level style with the pin already high) | 1st |
| Pin return high, after an acknowledge in level style | Flag clears | 3rd |
| Flag change | `cpu_irq` | one edge after the flag |

The bench drives every input on the falling clock edge and counts whole rising edges before it samples, also on a falling edge. Many checks also sample one edge early, to confirm that a result does not show up before its cycle. The mode and mask settings are swept over all four combinations for each request.

// File: rtl/irq_pkg.sv
// Package irq_pkg
// Shared field positions and widths of the interrupt pin controller's
// status/control register. Assumes an 8-bit register view.
package irq_pkg;
    localparam int REG_W    = 8;
    localparam int F_MODE   = 0;   // 1 = edge and level, 0 = edge only
    localparam int F_MASK   = 1;   // 1 = request kept from the CPU
    localparam int F_ACK    = 2;   // write 1 to acknowledge, reads 0
    localparam int F_PEND   = 3;   // pending request, read only
    localparam int F_LEVEL  = 4;   // synchronized pin level, read only
endpackage

// File: rtl/irq_pin_sync.sv
// Module irq_pin_sync
// Brings the asynchronous pin into the clock domain through STAGES flops
// and flags a falling edge of the synchronized level (1 then 0).
// Assumes STAGES >= 2. The chain keeps sampling during reset, so the level
// is settled by the time reset is released (reset held > STAGES cycles).
module irq_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic pin_n,
    output logic level,
    output logic fall
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain;
    logic         prev;

    // shift the raw pin through the synchronizer chain
    always_ff @(posedge clk) begin
        chain <= {chain[TOP-1:0], pin_n};
    end

    // remember the previous synchronized level for edge detection
    always_ff @(posedge clk) begin
        prev <= chain[TOP];
    end

    // decode the synchronized level and the falling edge
    always_comb begin
        level = chain[TOP];
        fall  = prev & ~chain[TOP];
    end
endmodule

// File: rtl/irq_req_latch.sv
// Module irq_req_latch
// Holds the interrupt request. A falling edge sets it and always wins.
// In edge style an acknowledge clears it at once. In level style it clears
// once an acknowledge has been seen and the pin is high, in either order.
// Assumes ack is a single-cycle pulse per acknowledge.
module irq_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic fall,
    input  logic ack,
    input  logic level_mode,
    input  logic pin_high,
    output logic pend
);
    logic ack_seen;
    logic ack_any;

    // combine a fresh acknowledge with a remembered one
    always_comb begin
        ack_any = ack | ack_seen;
    end

    // update the request and the remembered acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend     <= 1'b0;
            ack_seen <= 1'b0;
        end else if (fall) begin
            pend     <= 1'b1;
            ack_seen <= 1'b0;
        end else if (pend) begin
            if (!level_mode) begin
                if (ack) begin
                    pend <= 1'b0;
                end
                ack_seen <= 1'b0;
            end else if (ack_any && pin_high) begin
                pend     <= 1'b0;
                ack_seen <= 1'b0;
            end else begin
                ack_seen <= ack_any;
            end
        end else begin
            ack_seen <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_ctrl_regs.sv
// Module irq_ctrl_regs
// Status/control register: mode and mask bits, the write-one acknowledge
// strobe, the read view, and the registered CPU request.
// Assumes the write data is valid in the cycle reg_wr is high.
module irq_ctrl_regs
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             pend,
    input  logic             pin_level,
    output logic [REG_W-1:0] reg_rdata,
    output logic             level_mode,
    output logic             mask,
    output logic             ack_sw,
    output logic             cpu_irq
);
    // hold the writable control bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_mode <= 1'b0;
            mask       <= 1'b0;
        end else if (reg_wr) begin
            level_mode <= reg_wdata[F_MODE];
            mask       <= reg_wdata[F_MASK];
        end
    end

    // register the gated request toward the CPU
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_irq <= 1'b0;
        end else begin
            cpu_irq <= pend & ~mask;
        end
    end

    // form the acknowledge strobe and the read view
    always_comb begin
        ack_sw           = reg_wr & reg_wdata[F_ACK];
        reg_rdata        = '0;
        reg_rdata[F_MODE]  = level_mode;
        reg_rdata[F_MASK]  = mask;
        reg_rdata[F_PEND]  = pend;
        reg_rdata[F_LEVEL] = pin_level;
    end
endmodule

// File: rtl/ext_irq_ctrl.sv
// Module ext_irq_ctrl
// Top of the external interrupt pin controller: synchronizer and edge
// detector, request latch, and status/control register.
// Assumes one clock domain and rst_n held for more than SYNC_STAGES cycles.
module ext_irq_ctrl
    import irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_pin_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             vec_ack,
    output logic             cpu_irq
);
    logic pin_level;
    logic edge_fall;
    logic pend;
    logic level_mode;
    logic mask;
    logic ack_sw;
    logic ack_all;

    // merge both acknowledge sources
    always_comb begin
        ack_all = vec_ack | ack_sw;
    end

    irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .pin_n (irq_pin_n),
        .level (pin_level),
        .fall  (edge_fall)
    );

    irq_req_latch u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall       (edge_fall),
        .ack        (ack_all),
        .level_mode (level_mode),
        .pin_high   (pin_level),
        .pend       (pend)
    );

    irq_ctrl_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .pend       (pend),
        .pin_level  (pin_level),
        .reg_rdata  (reg_rdata),
        .level_mode (level_mode),
        .mask       (mask),
        .ack_sw     (ack_sw),
        .cpu_irq    (cpu_irq)
    );
endmodule

// File: rtl/ext_irq_chk.sv
// Module ext_irq_chk
// Property checker for ext_irq_ctrl, attached through bind.
module ext_irq_chk (
    input logic clk,
    input logic rst_n,
    input logic fall,
    input logic pend,
    input logic level_mode,
    input logic mask,
    input logic pin_level,
    input logic vec_ack,
    input logic ack_sw,
    input logic cpu_irq
);
    // R1: a detected edge sets the request on the next clock
    p_edge_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> pend);

    // R12: the request rises only after a detected edge
    p_rise_needs_edge_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(fall));

    // R2: edge style, acknowledge without a new edge clears
    p_edge_ack_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !level_mode && (vec_ack || ack_sw) && !fall) |=> !pend);

    // R4: level style, a low pin holds the request
    p_level_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && level_mode && !pin_level) |=> pend);

    // R7: a new edge wins over a same-cycle acknowledge
    p_edge_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && (vec_ack || ack_sw)) |=> pend);

    // R8: an unmasked pending request reaches the CPU one clock later
    p_unmasked_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !mask) |=> cpu_irq);

    // R8: masked or idle means no CPU request one clock later
    p_masked_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask || !pend) |=> !cpu_irq);
endmodule

bind ext_irq_ctrl ext_irq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fall       (edge_fall),
    .pend       (pend),
    .level_mode (level_mode),
    .mask       (mask),
    .pin_level  (pin_level),
    .vec_ack    (vec_ack),
    .ack_sw     (ack_sw),
    .cpu_irq    (cpu_irq)
);

// File: tb/tb_ext_irq_ctrl.sv
// Bench for ext_irq_ctrl: directed sequences plus a sweep of mode and mask.
module tb_ext_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       irq_pin_n = 1'b1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       vec_ack = 1'b0;
    logic       cpu_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    ext_irq_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_pin_n (irq_pin_n),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .vec_ack   (vec_ack),
        .cpu_irq   (cpu_irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one-cycle register write, then strobe low
    task automatic wr(input logic [7:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        step(1);
        reg_wr = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic vack();
        vec_ack = 1'b1;
        step(1);
        vec_ack = 1'b0;
    endtask

    function automatic int pend_f(); return int'(reg_rdata[3]); endfunction

    // drop the pin and wait until the request is latched
    task automatic raise();
        irq_pin_n = 1'b0;
        step(3);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(5);
        rst_n = 1'b1;
        step(1);
    endtask

    initial begin
        step(200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R9: reset state
        chk("R9 rdata after reset", int'(reg_rdata & 8'h0F), 0);
        chk("R9 cpu_irq after reset", int'(cpu_irq), 0);
        chk("R10 level idle high", int'(reg_rdata[4]), 1);

        // R12: no request with a high or rising pin
        step(5);
        chk("R12 no request idle", pend_f(), 0);

        // R1 and R10: timing of a falling edge
        irq_pin_n = 1'b0;
        step(1);
        chk("R10 level before 2 edges", int'(reg_rdata[4]), 1);
        step(1);
        chk("R10 level after 2 edges", int'(reg_rdata[4]), 0);
        chk("R1 not pending after 2 edges", pend_f(), 0);
        step(1);
        chk("R1 pending after 3 edges", pend_f(), 1);
        chk("R8 cpu_irq lags latch", int'(cpu_irq), 0);
        step(1);
        chk("R8 cpu_irq after 1 more", int'(cpu_irq), 1);

        // R2: vector acknowledge clears at once in edge style, pin still low
        vack();
        chk("R2 vec_ack clears", pend_f(), 0);
        step(1);
        chk("R8 cpu_irq drops", int'(cpu_irq), 0);
        step(4);
        chk("R2 low pin no relatch", pend_f(), 0);

        // R12: a rising pin makes no request
        irq_pin_n = 1'b1;
        step(5);
        chk("R12 rise no request", pend_f(), 0);

        // R3: software acknowledge
        raise();
        chk("R3 pending before sw ack", pend_f(), 1);
        wr(8'h04);
        chk("R3 sw ack clears", pend_f(), 0);

        // R11: ack reads 0, writing bit 3 is ignored
        chk("R11 ack reads 0", int'(reg_rdata[2]), 0);
        wr(8'h08);
        chk("R11 write pend ignored", pend_f(), 0);
        irq_pin_n = 1'b1;
        step(4);
        raise();
        wr(8'h00);
        chk("R11 write 0 to pend ignored", pend_f(), 1);
        vack();
        irq_pin_n = 1'b1;
        step(4);

        // R4: level style, ack while low, then pin returns high
        wr(8'h01);
        chk("R4 mode reads back", int'(reg_rdata[0]), 1);
        raise();
        vack();
        step(3);
        chk("R4 held while low", pend_f(), 1);
        irq_pin_n = 1'b1;
        step(2);
        chk("R4 not yet clear", pend_f(), 1);
        step(1);
        chk("R4 clears after pin high", pend_f(), 0);

        // R5: pin high first, then ack
        raise();
        irq_pin_n = 1'b1;
        step(5);
        chk("R5 held without ack", pend_f(), 1);
        wr(8'h05);
        chk("R5 ack clears", pend_f(), 0);

        // R6: new edge after an ack sets a new request (level style)
        raise();
        chk("R6 new request", pend_f(), 1);
        irq_pin_n = 1'b1;
        step(4);
        vack();
        chk("R6 cleared", pend_f(), 0);
        wr(8'h00);

        // R7: ack on the same edge as a new falling edge (edge style)
        raise();
        irq_pin_n = 1'b1;
        step(4);
        irq_pin_n = 1'b0;
        step(2);
        vack();
        chk("R7 edge wins", pend_f(), 1);
        vack();
        chk("R7 later ack clears", pend_f(), 0);
        irq_pin_n = 1'b1;
        step(4);

        // R8: sweep of mode and mask
        for (int m = 0; m < 4; m++) begin
            wr(8'(m));
            raise();
            chk("R8 pend ignores mask", pend_f(), 1);
            step(1);
            chk("R8 cpu_irq gate", int'(cpu_irq), ((m >> 1) & 1) ? 0 : 1);
            irq_pin_n = 1'b1;
            step(3);
            wr(8'(m | 4));
            chk("R8 sweep ack clears", pend_f(), 0);
            step(1);
            chk("R8 sweep cpu_irq off", int'(cpu_irq), 0);
        end

        // R9: reset with the pin held low, in level style
        wr(8'h01);
        raise();
        do_reset();
        chk("R9 reset clears pending", pend_f(), 0);
        chk("R9 reset clears mode", int'(reg_rdata[0]), 0);
        step(5);
        chk("R9 no request after reset", pend_f(), 0);
        chk("R9 cpu_irq low", int'(cpu_irq), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule